// File: doc/BRIEF.md
# Target Read Prefetch Controller

This block decides how a target memory read that falls inside a base address window pulls data from the local bus into the target read FIFO. The transaction arrives as a start strobe with a word address and the window's two-bit read-behaviour code. A data-phase strobe then takes one word from the head of the FIFO for each phase, and an end strobe closes the transaction. The block raises fetch requests on a valid/ready request port with a word address and a length. It writes the words the local bus returns into its own FIFO, in order. It also tells the bus side whether the transaction may burst.

The behaviour code sets the fetch pattern. A plain read fetches one word and may not burst. A line-style read fetches from the start address to the end of its cache line. A multiple-style read keeps streaming 16-word blocks at sequential word addresses. A prefetch-policy input is captured at the start of each transaction. It picks either a low-watermark refill or a refill that keeps going while the FIFO has room.

When the transaction ends, the FIFO is emptied at once and any request not yet accepted is withdrawn. The block then stays busy until every word still in flight has come back. It throws those words away, so no stale data can reach the next transaction.

Top module: `tgt_rd_prefetch`

## Requirements
- R1: Behaviour code 0 (plain read) raises exactly one request, with length 1 at the start address, and `burst_ok` stays 0 for the whole transaction.
- R2: Behaviour code 3 (reserved) is handled exactly as code 0.
- R3: Behaviour code 1 (line read) raises exactly one request at the start address. Its length is LINE_WORDS minus (start address modulo LINE_WORDS), and `burst_ok` is 1 while the transaction is open.
- R4: Behaviour code 2 (multiple read) raises requests of length PF_WORDS (16) at consecutive word addresses, beginning at the start address. `burst_ok` is 1 while the transaction is open.
- R5: With the policy input at 0 (conservative), a multiple read raises a new request only when fewer than LOW_MARK (8) words sit in the FIFO and no fetched word is still outstanding.
- R6: With the policy input at 1 (aggressive), a multiple read raises a new request whenever the FIFO's free space is at least PF_WORDS plus the words requested and not yet returned. The FIFO never overflows.
- R7: Returned words enter the FIFO in arrival order. `rd_data` shows the oldest word, `rd_count` the fill level, and each `phase_taken` pulse on a non-empty FIFO removes one word.
- R8: On `txn_end` the FIFO is empty from the next cycle, and any request not yet accepted is dropped. `flush_busy` stays 1 until all outstanding words have returned. Those words are discarded and never appear in the FIFO.
- R9: `txn_start` has no effect unless the block is idle. A start seen while the block is flushing raises no request.
- R10: Once raised, `req_valid` stays high with `req_addr` and `req_len` unchanged until `req_ready` accepts it. The only exception is that the transaction ends first.
- R11: After reset, `req_valid`, `burst_ok` and `flush_busy` are 0 and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Start of a target read transaction (pulse) |
| txn_kind | input | 2 | Read-behaviour code of the hit window |
| txn_addr | input | ADDR_W | Start word address |
| pf_aggr | input | 1 | Prefetch policy: 0 conservative, 1 aggressive |
| phase_taken | input | 1 | A data phase consumed the head word |
| txn_end | input | 1 | Transaction finished (pulse) |
| burst_ok | output | 1 | Transaction may carry more than one data phase |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Local bus accepts the request |
| req_addr | output | ADDR_W | Fetch word address |
| req_len | output | LEN_W | Fetch length in words |
| rsp_valid | input | 1 | One fetched word returns |
| rsp_data | input | DATA_W | Returned word |
| rd_data | output | DATA_W | Head word of the FIFO |
| rd_empty | output | 1 | FIFO empty |
| rd_count | output | CNT_W | FIFO fill level |
| flush_busy | output | 1 | Waiting for in-flight words to drain |

## Verification
The bench targets the line-length arithmetic for an address partway through a line. A design that fetched a full line there would show a length of 8 rather than 3 and would overrun into the next line. It pins the conservative watermark at exactly 8 versus 7 words, where an off-by-one refills too early or too late. It also pins the aggressive room test, where counting only FIFO words and ignoring outstanding ones would let a third 16-word request overflow the FIFO. Finally it ends a transaction while 28 words are still in flight and then starts a new read. If the flush were wrong, the FIFO would be non-empty after the end, or the new read's first word would be a stale word from the old stream, or a start issued during the flush would leak a request.

// File: rtl/tgt_rd_pkg.sv
package tgt_rd_pkg;

   typedef enum logic [1:0] {
      RK_SINGLE = 2'd0,
      RK_LINE   = 2'd1,
      RK_MULTI  = 2'd2,
      RK_RSVD   = 2'd3
   } rd_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_FLUSH  = 2'd2
   } rd_state_e;

endpackage

// File: rtl/tgt_rd_fifo.sv
module tgt_rd_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              empty
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("tgt_rd_fifo: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic              do_wr, do_rd, full;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_wr   = wr && !clr;
   assign do_rd   = rd && !empty && !clr;
   assign rd_data = mem[rp];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_wr) wp <= wp + AW'(1);
         if (do_rd) rp <= rp + AW'(1);
         count <= count + (do_wr ? CNT_W'(1) : '0) - (do_rd ? CNT_W'(1) : '0);
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      do_wr && !do_rd |-> !full);   // R6
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);               // R8

endmodule

// File: rtl/tgt_rd_linelen.sv
module tgt_rd_linelen #(
   parameter int ADDR_W     = 30,
   parameter int LINE_WORDS = 8,
   parameter int LEN_W      = 5
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [LEN_W-1:0]  len
);

   if (LINE_WORDS == 1) begin : g_unit_line
      assign len = LEN_W'(1);
   end else begin : g_multi_line
      localparam int LB = $clog2(LINE_WORDS);
      if ((1 << LB) != LINE_WORDS) begin : g_bad_line
         $error("tgt_rd_linelen: LINE_WORDS must be a power of two");
      end
      logic [LB-1:0] offs;
      assign offs = addr[LB-1:0];
      assign len  = LEN_W'(LINE_WORDS) - LEN_W'(offs);
   end

endmodule

// File: rtl/tgt_rd_policy.sv
module tgt_rd_policy #(
   parameter int DEPTH    = 32,
   parameter int PF_WORDS = 16,
   parameter int LOW_MARK = 8,
   parameter int CNT_W    = 6,
   parameter int OUT_W    = 6
) (
   input  logic             eligible,
   input  logic             aggressive,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic [OUT_W-1:0] outstanding,
   output logic             issue
);

   localparam int SW = ((OUT_W > CNT_W) ? OUT_W : CNT_W) + 2;

   logic [SW-1:0] free_w, need_w;
   logic          room_ok, low_ok;

   assign free_w  = SW'(DEPTH) - SW'(fifo_count);
   assign need_w  = SW'(PF_WORDS) + SW'(outstanding);
   assign room_ok = (free_w >= need_w);
   assign low_ok  = (fifo_count < CNT_W'(LOW_MARK)) && (outstanding == '0);
   assign issue   = eligible && (aggressive ? room_ok : low_ok);

endmodule

// File: rtl/tgt_rd_prefetch.sv
module tgt_rd_prefetch
   import tgt_rd_pkg::*;
#(
   parameter int ADDR_W     = 30,
   parameter int DATA_W     = 32,
   parameter int DEPTH      = 32,
   parameter int PF_WORDS   = 16,
   parameter int LOW_MARK   = 8,
   parameter int LINE_WORDS = 8,
   localparam int MAX_LEN   = (PF_WORDS > LINE_WORDS) ? PF_WORDS : LINE_WORDS,
   localparam int LEN_W     = $clog2(MAX_LEN + 1),
   localparam int CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              txn_start,
   input  logic [1:0]        txn_kind,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              pf_aggr,
   input  logic              phase_taken,
   input  logic              txn_end,
   output logic              burst_ok,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [LEN_W-1:0]  req_len,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic [CNT_W-1:0]  rd_count,
   output logic              flush_busy
);

   localparam int OUT_W = $clog2(DEPTH + MAX_LEN + 1);

   if (DEPTH < PF_WORDS + LOW_MARK - 1) begin : g_bad_depth
      $error("tgt_rd_prefetch: DEPTH too small for watermark refill");
   end
   if (LINE_WORDS > DEPTH) begin : g_bad_line
      $error("tgt_rd_prefetch: LINE_WORDS exceeds DEPTH");
   end

   rd_state_e         state;
   rd_kind_e          kind_q;
   logic              aggr_q, burst_q;
   logic [ADDR_W-1:0] nxt_addr;
   logic [OUT_W-1:0]  out_q;
   logic [LEN_W-1:0]  line_len;
   logic              hs, issue, eligible;
   logic              f_clr, f_wr, f_rd;

   assign hs       = req_valid && req_ready;
   assign eligible = (state == ST_ACTIVE) && (kind_q == RK_MULTI) && !req_valid && !txn_end;

   tgt_rd_linelen #(
      .ADDR_W    (ADDR_W),
      .LINE_WORDS(LINE_WORDS),
      .LEN_W     (LEN_W)
   ) u_linelen (
      .addr(txn_addr),
      .len (line_len)
   );

   tgt_rd_policy #(
      .DEPTH   (DEPTH),
      .PF_WORDS(PF_WORDS),
      .LOW_MARK(LOW_MARK),
      .CNT_W   (CNT_W),
      .OUT_W   (OUT_W)
   ) u_policy (
      .eligible   (eligible),
      .aggressive (aggr_q),
      .fifo_count (rd_count),
      .outstanding(out_q),
      .issue      (issue)
   );

   assign f_clr = (state == ST_ACTIVE) && txn_end;
   assign f_wr  = rsp_valid && (state == ST_ACTIVE);
   assign f_rd  = phase_taken && (state == ST_ACTIVE);

   tgt_rd_fifo #(
      .DATA_W(DATA_W),
      .DEPTH (DEPTH)
   ) u_fifo (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (f_clr),
      .wr     (f_wr),
      .wr_data(rsp_data),
      .rd     (f_rd),
      .rd_data(rd_data),
      .count  (rd_count),
      .empty  (rd_empty)
   );

   // transaction control and request register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind_q    <= RK_SINGLE;
         aggr_q    <= 1'b0;
         burst_q   <= 1'b0;
         nxt_addr  <= '0;
         req_valid <= 1'b0;
         req_addr  <= '0;
         req_len   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (txn_start) begin
                  state    <= ST_ACTIVE;
                  kind_q   <= rd_kind_e'(txn_kind);
                  aggr_q   <= pf_aggr;
                  burst_q  <= (txn_kind == RK_LINE) || (txn_kind == RK_MULTI);
                  nxt_addr <= txn_addr;
                  if (txn_kind != RK_MULTI) begin
                     req_valid <= 1'b1;
                     req_addr  <= txn_addr;
                     req_len   <= (txn_kind == RK_LINE) ? line_len : LEN_W'(1);
                  end
               end
            end
            ST_ACTIVE: begin
               if (txn_end) begin
                  state     <= ST_FLUSH;
                  burst_q   <= 1'b0;
                  req_valid <= 1'b0;
               end else if (hs) begin
                  req_valid <= 1'b0;
                  nxt_addr  <= nxt_addr + ADDR_W'(req_len);
               end else if (issue) begin
                  req_valid <= 1'b1;
                  req_addr  <= nxt_addr;
                  req_len   <= LEN_W'(PF_WORDS);
               end
            end
            default: begin
               if (out_q == '0) state <= ST_IDLE;
            end
         endcase
      end
   end

   // words requested but not yet returned
   always_ff @(posedge clk) begin
      if (!rst_n) out_q <= '0;
      else out_q <= out_q + (hs ? OUT_W'(req_len) : '0) - (rsp_valid ? OUT_W'(1) : '0);
   end

   assign burst_ok   = burst_q;
   assign flush_busy = (state == ST_FLUSH);

   AST_SINGLE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (kind_q == RK_SINGLE || kind_q == RK_RSVD) |-> req_len == LEN_W'(1) && !burst_ok);   // R1
   AST_MULTI_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && kind_q == RK_MULTI |-> req_len == LEN_W'(PF_WORDS));   // R4
   AST_CONS_WATERMARK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) && kind_q == RK_MULTI && !aggr_q
      |-> $past(rd_count) < CNT_W'(LOW_MARK) && $past(out_q) == '0);   // R5
   AST_AGGR_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) && kind_q == RK_MULTI && aggr_q
      |-> 32'(DEPTH) - 32'($past(rd_count)) >= 32'(PF_WORDS) + 32'($past(out_q)));   // R6
   AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> out_q != '0);   // R7
   AST_NO_REQ_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      state != ST_ACTIVE |-> !req_valid);   // R8
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy |-> rd_empty);   // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      flush_busy && txn_start |=> !req_valid);   // R9
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready && !txn_end |=> req_valid && $stable(req_addr) && $stable(req_len));   // R10

endmodule

// File: tb/tgt_rd_prefetch_tb.sv
module tgt_rd_prefetch_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 30;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 32;
   localparam int PF     = 16;
   localparam int LOWM   = 8;
   localparam int LINE   = 8;
   localparam int LEN_W  = $clog2(PF + 1);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam logic [31:0] KEY = 32'h5A00_0000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              txn_start = 1'b0;
   logic [1:0]        txn_kind = 2'd0;
   logic [ADDR_W-1:0] txn_addr = '0;
   logic              pf_aggr = 1'b0;
   logic              phase_taken = 1'b0;
   logic              txn_end = 1'b0;
   logic              burst_ok, req_valid;
   logic              req_ready = 1'b1;
   logic [ADDR_W-1:0] req_addr;
   logic [LEN_W-1:0]  req_len;
   logic              rsp_valid = 1'b0;
   logic [DATA_W-1:0] rsp_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic              rd_empty;
   logic [CNT_W-1:0]  rd_count;
   logic              flush_busy;

   int checks = 0;
   int errors = 0;
   int req_cnt = 0;
   int last_addr = 0;
   int last_len = 0;
   bit rsp_en = 1'b1;
   logic [31:0] rq[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   tgt_rd_prefetch #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
      .PF_WORDS(PF), .LOW_MARK(LOWM), .LINE_WORDS(LINE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_kind(txn_kind),
      .txn_addr(txn_addr), .pf_aggr(pf_aggr), .phase_taken(phase_taken),
      .txn_end(txn_end), .burst_ok(burst_ok), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rd_data(rd_data),
      .rd_empty(rd_empty), .rd_count(rd_count), .flush_busy(flush_busy)
   );

   // local bus model: record accepted requests, return words in order
   always @(posedge clk) begin
      if (rst_n && req_valid && req_ready) begin
         req_cnt   = req_cnt + 1;
         last_addr = int'(req_addr);
         last_len  = int'(req_len);
         for (int i = 0; i < int'(req_len); i++) rq.push_back(32'(req_addr) + 32'(i));
      end
   end

   always @(negedge clk) begin
      if (rsp_en && rq.size() > 0) begin
         rsp_valid <= 1'b1;
         rsp_data  <= rq.pop_front() ^ KEY;
      end else begin
         rsp_valid <= 1'b0;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic start(input logic [1:0] k, input int a, input bit ag);
      txn_kind  = k;
      txn_addr  = ADDR_W'(a);
      pf_aggr   = ag;
      txn_start = 1'b1;
      step();
      txn_start = 1'b0;
   endtask

   task automatic wait_count(input int n, input string tag);
      int t = 0;
      while (int'(rd_count) != n && t < 300) begin step(); t++; end
      check(int'(rd_count) == n, tag, int'(rd_count), n);
   endtask

   task automatic wait_req(input int n, input string tag);
      int t = 0;
      while (req_cnt < n && t < 300) begin step(); t++; end
      check(req_cnt == n, tag, req_cnt, n);
   endtask

   task automatic pop_run(input int a, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         check(!rd_empty && rd_data == (32'(a + i) ^ KEY), tag, int'(rd_data), int'(32'(a + i) ^ KEY));
         phase_taken = 1'b1;
         step();
      end
      phase_taken = 1'b0;
   endtask

   task automatic end_txn(input string tag);
      int t = 0;
      rsp_en  = 1'b1;
      txn_end = 1'b1;
      step();
      txn_end = 1'b0;
      while (flush_busy && t < 300) begin step(); t++; end
      check(!flush_busy && rd_empty, tag, int'(flush_busy), 0);
   endtask

   task automatic t_reset();
      check(!req_valid && !burst_ok && !flush_busy, "R11 outputs", {req_valid, burst_ok, flush_busy}, 0);
      check(rd_empty && rd_count == 0, "R11 fifo", int'(rd_count), 0);
   endtask

   task automatic t_single(input logic [1:0] k, input int a, input string tag);
      int base = req_cnt;
      start(k, a, 1'b0);
      check(!burst_ok, tag, int'(burst_ok), 0);
      wait_count(1, tag);
      check(req_cnt == base + 1 && last_len == 1 && last_addr == a, tag, last_addr, a);
      step(10);
      check(req_cnt == base + 1 && rd_count == 1, tag, req_cnt, base + 1);
      pop_run(a, 1, "R7 single data");
      end_txn(tag);
   endtask

   task automatic t_line();
      int base = req_cnt;
      start(2'd1, 'h105, 1'b0);
      check(burst_ok, "R3 burst_ok", int'(burst_ok), 1);
      wait_count(3, "R3 fill");
      check(last_len == 3 && last_addr == 'h105, "R3 length", last_len, 3);
      step(10);
      check(req_cnt == base + 1, "R3 single request", req_cnt, base + 1);
      pop_run('h105, 3, "R7 line data");
      end_txn("R8 line end");
   endtask

   task automatic t_cons();
      int base = req_cnt;
      start(2'd2, 'h200, 1'b0);
      check(burst_ok, "R4 burst_ok", int'(burst_ok), 1);
      wait_count(16, "R4 first fill");
      check(req_cnt == base + 1 && last_len == 16 && last_addr == 'h200, "R4 first req", last_addr, 'h200);
      step(10);
      check(req_cnt == base + 1, "R5 no refill at 16", req_cnt, base + 1);
      pop_run('h200, 8, "R7 cons data");
      step(5);
      check(req_cnt == base + 1, "R5 no refill at 8", req_cnt, base + 1);
      pop_run('h208, 1, "R7 cons data");
      wait_req(base + 2, "R5 refill below 8");
      check(last_addr == 'h210 && last_len == 16, "R4 sequential addr", last_addr, 'h210);
      wait_count(23, "R5 refill lands");
      end_txn("R8 cons end");
   endtask

   task automatic t_aggr();
      int base = req_cnt;
      start(2'd2, 'h300, 1'b1);
      wait_count(32, "R6 fill to depth");
      check(req_cnt == base + 2 && last_addr == 'h310, "R6 two requests", req_cnt, base + 2);
      pop_run('h300, 15, "R7 aggr data");
      step(5);
      check(req_cnt == base + 2, "R6 no req with 15 free", req_cnt, base + 2);
      pop_run('h30F, 1, "R7 aggr data");
      wait_req(base + 3, "R6 req with 16 free");
      check(last_addr == 'h320, "R6 third addr", last_addr, 'h320);
      wait_count(32, "R6 refill to depth");
      end_txn("R8 aggr end");
   endtask

   task automatic t_flush();
      int base = req_cnt;
      rsp_en = 1'b0;
      start(2'd2, 'h400, 1'b1);
      wait_req(base + 2, "R6 flush setup");
      step(2);
      rsp_en = 1'b1;
      step(4);
      rsp_en = 1'b0;
      step(3);
      check(rd_count == 4, "R7 partial fill", int'(rd_count), 4);
      txn_end = 1'b1;
      step();
      txn_end = 1'b0;
      check(rd_empty && flush_busy, "R8 flush starts", int'(rd_count), 0);
      start(2'd0, 'h40, 1'b0);
      step(5);
      check(req_cnt == base + 2 && !req_valid, "R9 start ignored in flush", req_cnt, base + 2);
      rsp_en = 1'b1;
      begin
         int t = 0;
         while (flush_busy && t < 300) begin step(); t++; end
      end
      step(3);
      check(!flush_busy && rd_empty && req_cnt == base + 2, "R8 in-flight dropped", int'(rd_count), 0);
      start(2'd0, 'h40, 1'b0);
      wait_count(1, "R8 clean restart");
      pop_run('h40, 1, "R8 no stale word");
      end_txn("R8 restart end");
   endtask

   task automatic t_backpressure();
      int base = req_cnt;
      req_ready = 1'b0;
      start(2'd2, 'h500, 1'b0);
      step(6);
      check(req_valid && req_addr == 'h500 && req_len == 16 && req_cnt == base,
            "R10 request held", int'(req_addr), 'h500);
      req_ready = 1'b1;
      wait_count(16, "R10 accepted");
      end_txn("R10 end");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      t_reset();
      t_single(2'd0, 'h100, "R1 plain read");
      t_single(2'd3, 'h120, "R2 reserved code");
      t_line();
      t_cons();
      t_aggr();
      t_flush();
      t_backpressure();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule